// File: doc/BRIEF.md
# Gap-Weighted Victim Selector

This block selects the way to evict for one set-associative second-level cache. It does not use recency. Each line carries a weight that estimates the expected reciprocal of the time between two successive references to that line. The line with the smallest weight in the set is the one least likely to be touched soon, so it is evicted. Gap statistics are learned while the cache runs. They are kept per class, not per line, and a line's class is its saturating reference count.

The cache controller reports every access: set, way, and whether it was a hit or a fill. The block keeps the line metadata and the class statistics in step with those reports. When the controller needs room in a set, it raises a replacement request with the set index. One cycle later the block presents the victim way with a valid flag. Tag and data storage, coherence and write-back are handled outside.

Top module: `rfg_victim_unit`

## Requirements
- R1: With all ways of the requested set valid, the victim is the way whose class weight is smallest.
- R2: When several valid ways share the smallest weight, the lowest-numbered of them is chosen.
- R3: If any way of the requested set is invalid, the lowest-numbered invalid way is chosen, whatever the weights.
- R4: `vic_valid` is high in exactly the cycle after a cycle with `rep_req` high, and low otherwise. `vic_way` changes only when a request is answered. The decision uses the state as it was in the request cycle.
- R5: An 8-bit time counter advances by one, modulo 256, on every cycle with `acc_valid` high. A fill or a valid hit stamps the line with the counter value of that cycle. The gap on a hit is (counter − stamp) mod 256.
- R6: A fill makes the line valid with reference count 1. Each valid hit adds one to the count, saturating at 7. A line's class is its reference count before the current hit.
- R7: On a valid hit, the accumulator of the line's class gains 2^(8−k), where k is the bit position of the gap's leading one (k = 0 for gaps 0 and 1). That class's sample count gains one.
- R8: When a sample count would reach 16, the count becomes 8 and the accumulator becomes half of its new sum, rounded down.
- R9: Class weights start at zero. Each cycle one class, taken in order 0..7 starting from class 0 after reset, has its weight set to floor(accumulator / count) from the state before that edge, or to 0 if its count is zero.
- R10: A hit reported for an invalid line changes no metadata and no statistics. It still advances the time counter.
- R11: After reset every line is invalid, all statistics and weights are zero, `vic_valid` is 0 and `vic_way` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Cache access report strobe |
| acc_set | input | 3 | Set of the reported access |
| acc_way | input | 2 | Way of the reported access |
| acc_hit | input | 1 | 1 = hit on the line, 0 = line filled |
| rep_req | input | 1 | Replacement request |
| rep_set | input | 3 | Set needing a victim |
| vic_way | output | 2 | Chosen victim way |
| vic_valid | output | 1 | Victim way is valid this cycle |

## Verification
Requests on empty and partly filled sets show whether invalid ways take priority over weights. Freshly filled sets, where every way has weight zero, show whether ties go to the lowest index. A line hit back-to-back against lines hit after long gaps separates classes with high and low weights, so a reversed comparison or a wrong reciprocal moves the victim. Repeated hits on one line drive a class into halving, hits on empty lines test that they are ignored, and a long random mix of fills, hits and requests on a few sets wraps the time counter. That mix also lands requests on the same cycle as accesses and as weight refreshes. A behavioural model in the bench is compared with the outputs every cycle.

// File: rtl/rfg_pkg.sv
package rfg_pkg;
  // Bit index of the highest set bit; 0 when the value is 0 or 1.
  function automatic int lead_pos(input logic [31:0] g);
    int p;
    p = 0;
    for (int i = 0; i < 32; i++) begin
      if (g[i]) p = i;
    end
    return p;
  endfunction

  // Fixed-point reciprocal approximation of a gap with FRAC fraction bits.
  function automatic int recip_shift(input logic [31:0] g, input int frac);
    return frac - lead_pos(g);
  endfunction
endpackage

// File: rtl/rfg_line_meta.sv
module rfg_line_meta #(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  parameter int TS_W = 8,
  parameter int RC_W = 3,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_valid,
  input  logic [SET_W-1:0]           acc_set,
  input  logic [WAY_W-1:0]           acc_way,
  input  logic                       acc_hit,
  input  logic [TS_W-1:0]            time_now,
  input  logic [SET_W-1:0]           rd_set,
  output logic                       hit_evt,
  output logic [RC_W-1:0]            hit_class,
  output logic [TS_W-1:0]            hit_gap,
  output logic [WAYS-1:0]            rd_valid,
  output logic [WAYS-1:0][RC_W-1:0]  rd_class
);
  localparam logic [RC_W-1:0] RC_MAX = '1;

  logic             val_q [SETS][WAYS];
  logic [RC_W-1:0]  rc_q  [SETS][WAYS];
  logic [TS_W-1:0]  ts_q  [SETS][WAYS];
  logic             fill_evt;

  assign hit_evt   = acc_valid && acc_hit && val_q[acc_set][acc_way];
  assign fill_evt  = acc_valid && !acc_hit;
  assign hit_class = rc_q[acc_set][acc_way];
  assign hit_gap   = time_now - ts_q[acc_set][acc_way];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      rd_valid[w] = val_q[rd_set][w];
      rd_class[w] = rc_q[rd_set][w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          val_q[s][w] <= 1'b0;
          rc_q[s][w]  <= '0;
          ts_q[s][w]  <= '0;
        end
      end
    end else if (fill_evt) begin
      val_q[acc_set][acc_way] <= 1'b1;
      rc_q[acc_set][acc_way]  <= RC_W'(1);
      ts_q[acc_set][acc_way]  <= time_now;
    end else if (hit_evt) begin
      if (hit_class != RC_MAX) rc_q[acc_set][acc_way] <= hit_class + 1'b1;
      ts_q[acc_set][acc_way] <= time_now;
    end
  end
endmodule

// File: rtl/rfg_class_stats.sv
module rfg_class_stats
  import rfg_pkg::*;
#(
  parameter int TS_W = 8,
  parameter int RC_W = 3,
  parameter int SC_W = 4,
  localparam int NCLS  = 1 << RC_W,
  localparam int ACC_W = SC_W + TS_W + 1,
  localparam int WT_W  = TS_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hit_evt,
  input  logic [RC_W-1:0]            hit_class,
  input  logic [TS_W-1:0]            hit_gap,
  output logic [NCLS-1:0][WT_W-1:0]  cls_wt,
  output logic                       samp_sat_evt,
  output logic [WT_W-1:0]            wt_upd_val
);
  localparam logic [SC_W-1:0] SC_MAX  = '1;
  localparam logic [SC_W-1:0] SC_HALF = SC_W'(1 << (SC_W - 1));

  logic [ACC_W-1:0] acc_q [NCLS];
  logic [SC_W-1:0]  cnt_q [NCLS];
  logic [RC_W-1:0]  rr_q;
  logic [ACC_W-1:0] contrib;
  logic [ACC_W-1:0] acc_sum;

  assign contrib      = ACC_W'(1) << recip_shift(32'(hit_gap), TS_W);
  assign acc_sum      = acc_q[hit_class] + contrib;
  assign samp_sat_evt = hit_evt && (cnt_q[hit_class] == SC_MAX);
  assign wt_upd_val   = (cnt_q[rr_q] == '0) ? '0
                        : WT_W'(acc_q[rr_q] / ACC_W'(cnt_q[rr_q]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCLS; c++) begin
        acc_q[c]  <= '0;
        cnt_q[c]  <= '0;
        cls_wt[c] <= '0;
      end
      rr_q <= '0;
    end else begin
      cls_wt[rr_q] <= wt_upd_val;
      rr_q         <= rr_q + 1'b1;
      if (samp_sat_evt) begin
        acc_q[hit_class] <= acc_sum >> 1;
        cnt_q[hit_class] <= SC_HALF;
      end else if (hit_evt) begin
        acc_q[hit_class] <= acc_sum;
        cnt_q[hit_class] <= cnt_q[hit_class] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rfg_victim_pick.sv
module rfg_victim_pick #(
  parameter int WAYS = 4,
  parameter int RC_W = 3,
  parameter int WT_W = 9,
  localparam int NCLS  = 1 << RC_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            rd_valid,
  input  logic [WAYS-1:0][RC_W-1:0]  rd_class,
  input  logic [NCLS-1:0][WT_W-1:0]  cls_wt,
  output logic [WAY_W-1:0]           pick_way,
  output logic                       pick_inv_any
);
  logic [WT_W-1:0] best;

  always_comb begin
    pick_way     = '0;
    pick_inv_any = 1'b0;
    best         = cls_wt[rd_class[0]];
    for (int w = 0; w < WAYS; w++) begin
      if (!rd_valid[w] && !pick_inv_any) begin
        pick_inv_any = 1'b1;
        pick_way     = WAY_W'(w);
      end
    end
    if (!pick_inv_any) begin
      for (int w = 1; w < WAYS; w++) begin
        if (cls_wt[rd_class[w]] < best) begin
          best     = cls_wt[rd_class[w]];
          pick_way = WAY_W'(w);
        end
      end
    end
  end
endmodule

// File: rtl/rfg_victim_unit.sv
module rfg_victim_unit #(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  parameter int TS_W = 8,
  parameter int RC_W = 3,
  parameter int SC_W = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int NCLS  = 1 << RC_W,
  localparam int WT_W  = TS_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [SET_W-1:0] acc_set,
  input  logic [WAY_W-1:0] acc_way,
  input  logic             acc_hit,
  input  logic             rep_req,
  input  logic [SET_W-1:0] rep_set,
  output logic [WAY_W-1:0] vic_way,
  output logic             vic_valid
);
  logic [TS_W-1:0]            time_now;
  logic                       hit_evt;
  logic [RC_W-1:0]            hit_class;
  logic [TS_W-1:0]            hit_gap;
  logic [WAYS-1:0]            rd_valid;
  logic [WAYS-1:0][RC_W-1:0]  rd_class;
  logic [NCLS-1:0][WT_W-1:0]  cls_wt;
  logic                       samp_sat_evt;
  logic [WT_W-1:0]            wt_upd_val;
  logic [WAY_W-1:0]           pick_way;
  logic                       pick_inv_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_now <= '0;
    else if (acc_valid) time_now <= time_now + 1'b1;
  end

  rfg_line_meta #(.SETS(SETS), .WAYS(WAYS), .TS_W(TS_W), .RC_W(RC_W)) u_meta (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_way(acc_way), .acc_hit(acc_hit), .time_now(time_now), .rd_set(rep_set),
    .hit_evt(hit_evt), .hit_class(hit_class), .hit_gap(hit_gap),
    .rd_valid(rd_valid), .rd_class(rd_class)
  );

  rfg_class_stats #(.TS_W(TS_W), .RC_W(RC_W), .SC_W(SC_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .hit_evt(hit_evt), .hit_class(hit_class),
    .hit_gap(hit_gap), .cls_wt(cls_wt), .samp_sat_evt(samp_sat_evt),
    .wt_upd_val(wt_upd_val)
  );

  rfg_victim_pick #(.WAYS(WAYS), .RC_W(RC_W), .WT_W(WT_W)) u_pick (
    .rd_valid(rd_valid), .rd_class(rd_class), .cls_wt(cls_wt),
    .pick_way(pick_way), .pick_inv_any(pick_inv_any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vic_way   <= '0;
      vic_valid <= 1'b0;
    end else begin
      vic_valid <= rep_req;
      if (rep_req) vic_way <= pick_way;
    end
  end
endmodule

// File: rtl/rfg_victim_chk.sv
module rfg_victim_chk #(
  parameter int TS_W = 8,
  parameter int RC_W = 3,
  localparam int WT_W = TS_W + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_valid,
  input logic            rep_req,
  input logic            vic_valid,
  input logic [TS_W-1:0] time_now,
  input logic            hit_evt,
  input logic [RC_W-1:0] hit_class,
  input logic [WT_W-1:0] wt_upd_val
);
  localparam logic [WT_W-1:0] WT_CEIL = WT_W'(1 << TS_W);

  p_vic_follows_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rep_req |=> vic_valid);

  p_vic_only_on_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rep_req |=> !vic_valid);

  p_time_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> time_now == TS_W'($past(time_now) + 1'b1));

  p_time_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(time_now));

  p_hit_class_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |-> hit_class != '0);

  p_weight_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wt_upd_val <= WT_CEIL);
endmodule

bind rfg_victim_unit rfg_victim_chk #(.TS_W(TS_W), .RC_W(RC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .rep_req(rep_req),
  .vic_valid(vic_valid), .time_now(time_now), .hit_evt(hit_evt),
  .hit_class(hit_class), .wt_upd_val(wt_upd_val)
);

// File: tb/rfg_victim_unit_tb.sv
module rfg_victim_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic [2:0] acc_set = '0;
  logic [1:0] acc_way = '0;
  logic       acc_hit = 1'b0;
  logic       rep_req = 1'b0;
  logic [2:0] rep_set = '0;
  logic [1:0] vic_way;
  logic       vic_valid;

  always #4 clk = ~clk;

  rfg_victim_unit u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_way(acc_way), .acc_hit(acc_hit), .rep_req(rep_req), .rep_set(rep_set),
    .vic_way(vic_way), .vic_valid(vic_valid)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;
  string phase = "R11";

  // behavioural model state
  int m_val [8][4];
  int m_rc  [8][4];
  int m_ts  [8][4];
  int m_acc [8];
  int m_cnt [8];
  int m_w   [8];
  int m_rr, m_t;
  int exp_valid, exp_way;
  string exp_tag;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s (phase %s) actual=%0d expected=%0d at cycle %0d", tag, phase, act, expv, cycles);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 8; s++)
        for (int w = 0; w < 4; w++) begin m_val[s][w] = 0; m_rc[s][w] = 0; m_ts[s][w] = 0; end
      for (int c = 0; c < 8; c++) begin m_acc[c] = 0; m_cnt[c] = 0; m_w[c] = 0; end
      m_rr = 0; m_t = 0; exp_valid = 0; exp_way = 0; exp_tag = "R11";
    end else begin
      // victim from state before the edge
      if (rep_req) begin
        int inv, best, nbest;
        inv = -1;
        for (int w = 3; w >= 0; w--) if (m_val[rep_set][w] == 0) inv = w;
        exp_valid = 1;
        if (inv >= 0) begin
          exp_way = inv; exp_tag = "R3";
        end else begin
          best = 1 << 30; nbest = 0;
          for (int w = 0; w < 4; w++) begin
            int wt;
            wt = m_w[m_rc[rep_set][w]];
            if (wt < best) begin best = wt; exp_way = w; end
          end
          for (int w = 0; w < 4; w++) if (m_w[m_rc[rep_set][w]] == best) nbest++;
          exp_tag = (nbest > 1) ? "R2" : "R1";
        end
      end else begin
        exp_valid = 0;
      end
      // one class weight refreshed per cycle
      m_w[m_rr] = (m_cnt[m_rr] == 0) ? 0 : m_acc[m_rr] / m_cnt[m_rr];
      m_rr = (m_rr + 1) % 8;
      if (acc_valid) begin
        if (!acc_hit) begin
          m_val[acc_set][acc_way] = 1; m_rc[acc_set][acc_way] = 1; m_ts[acc_set][acc_way] = m_t;
        end else if (m_val[acc_set][acc_way] != 0) begin
          int g, k, c;
          g = (m_t - m_ts[acc_set][acc_way]) & 255;
          k = 0;
          while (g > 1) begin g = g / 2; k++; end
          c = m_rc[acc_set][acc_way];
          m_acc[c] += 256 >> k;
          m_cnt[c] += 1;
          if (m_cnt[c] == 16) begin m_cnt[c] = 8; m_acc[c] = m_acc[c] / 2; end
          if (m_rc[acc_set][acc_way] < 7) m_rc[acc_set][acc_way]++;
          m_ts[acc_set][acc_way] = m_t;
        end
        m_t = (m_t + 1) & 255;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(int'(vic_valid) == exp_valid, "R4", int'(vic_valid), exp_valid);
      if (exp_valid != 0) check(int'(vic_way) == exp_way, exp_tag, int'(vic_way), exp_way);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic step(input bit av, input int s, input int w, input bit h, input bit rq, input int rs);
    acc_valid = av; acc_set = 3'(s); acc_way = 2'(w); acc_hit = h;
    rep_req = rq; rep_set = 3'(rs);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(vic_valid == 1'b0, "R11", int'(vic_valid), 0);
    check(vic_way == 2'd0, "R11", int'(vic_way), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(vic_valid == 1'b0, "R11", int'(vic_valid), 0);

    phase = "R3";
    step(0, 0, 0, 0, 1, 0);
    step(1, 0, 0, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    idle(2);

    phase = "R2";
    for (int w = 0; w < 4; w++) step(1, 1, w, 0, 0, 0);
    idle(9);
    step(0, 0, 0, 0, 1, 1);
    idle(2);

    phase = "R7";
    for (int i = 0; i < 4; i++) step(1, 1, 2, 1, 0, 0);
    for (int i = 0; i < 40; i++) step(1, 6, i % 4, 0, 0, 0);
    step(1, 1, 3, 1, 0, 0);
    for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 0, 0);
    idle(9);
    step(0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 1, 6);
    idle(2);

    phase = "R10";
    step(1, 5, 1, 1, 0, 0);
    step(0, 0, 0, 0, 1, 5);
    step(1, 5, 0, 0, 0, 0);
    step(1, 5, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1, 5);
    idle(2);

    phase = "R8";
    for (int w = 0; w < 4; w++) step(1, 2, w, 0, 0, 0);
    for (int i = 0; i < 60; i++) step(1, 2, 0, 1, (i % 7) == 0, 2);
    for (int i = 0; i < 30; i++) step(1, 2, 1 + (i % 3), 1, (i % 5) == 0, 2);
    idle(9);
    step(0, 0, 0, 0, 1, 2);
    idle(2);

    phase = "R9";
    for (int i = 0; i < 4000; i++) begin
      bit av, h, rq;
      av = ($urandom % 10) < 7;
      h  = ($urandom % 10) < 7;
      rq = ($urandom % 10) < 3;
      step(av, $urandom % 4, $urandom % 4, h, rq, $urandom % 4);
    end
    idle(3);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule